// File: doc/BRIEF.md
# Dual-Edge Background Data Generator

This block supplies the data words a memory test engine writes to, and expects back from, the array under test. It holds a data background register and drives two words from it on every internal clock. One word serves the rising-edge beat and the other the falling-edge beat. Each word is either the background or its bitwise complement, chosen separately. This yields solid and checkerboard patterns without a second background register.

Every instruction carries a 3-bit data function code. Four of the codes pick the true/inverted choice for the two beats. The other four change the background itself: step up, step down, reload it from the tester's data, or leave it alone. The tester's data arrives through a capture register. That register samples the external word on a strobe marking an edge of the slow tester clock, and it keeps that value until the next strobe. Serialising the beats onto the data bus and comparing read data belong to other blocks.

Top module: `dual_edge_bg_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the background, the capture register and the polarity selection are all cleared. The polarity selection becomes true/true. From that edge on, `even_data` and `odd_data` are both zero.
- R2: An accepted instruction with code 0 to 3 sets the polarity. Code bit 1 inverts the even beat and code bit 0 inverts the odd beat: 0 = true/true, 1 = true/inverted, 2 = inverted/true, 3 = inverted/inverted. The background stays unchanged, and the outputs show the new selection from the edge that accepts the instruction.
- R3: Code 4 adds one to the background, wrapping from all ones to zero at DATA_W bits.
- R4: Code 5 subtracts one from the background, wrapping from zero to all ones at DATA_W bits.
- R5: Code 6 copies the capture register into the background.
- R6: Code 7 leaves the background unchanged, so both outputs keep their values.
- R7: Codes 4 to 7 keep the polarity selection in force. The outputs show the new background under that same selection from the accepting edge.
- R8: When `instr_valid` is low, the background and the polarity are unchanged, whatever `data_fn` holds.
- R9: A high `ext_capture` at a rising edge stores `ext_word` in the capture register. A code 6 accepted at that same edge loads the value the capture register held before the edge.
- R10: Capturing a tester word does not change `even_data` or `odd_data` until a code 6 loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal test clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Accepts `data_fn` at this edge |
| data_fn | input | 3 | Data function code of the instruction |
| ext_capture | input | 1 | Strobe marking a tester clock edge; samples `ext_word` |
| ext_word | input | DATA_W | Data word from the tester |
| even_data | output | DATA_W | Word for the rising-edge beat |
| odd_data | output | DATA_W | Word for the falling-edge beat |

## Verification
Both outputs are registered from the next-state background and polarity. A wrong background or polarity bit therefore shows at the ports in the cycle right after the edge that produced it. A polarity error appears as a changed XOR of the two words. A background error appears in both words at once. A corrupted capture register stays hidden until the next code 6, so the bench follows each capture with a load before checking further. Every cycle is compared against a behavioural model, which covers the cases where a hidden error surfaces several instructions later.

// File: rtl/dbg_pkg.sv
// Shared types for the dual-edge background generator.
// Assumes the data function code is exactly 3 bits wide.
package dbg_pkg;

    localparam int FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_TRUE_TRUE = 3'd0,
        FN_TRUE_INV  = 3'd1,
        FN_INV_TRUE  = 3'd2,
        FN_INV_INV   = 3'd3,
        FN_STEP_UP   = 3'd4,
        FN_STEP_DN   = 3'd5,
        FN_LOAD_EXT  = 3'd6,
        FN_KEEP      = 3'd7
    } dbg_fn_e;

    typedef enum logic [1:0] {
        BG_HOLD,
        BG_INC,
        BG_DEC,
        BG_LOAD
    } bg_op_e;

    typedef struct packed {
        logic inv_even;
        logic inv_odd;
    } beat_pol_t;

    localparam beat_pol_t POL_RESET = '{inv_even: 1'b0, inv_odd: 1'b0};

endpackage

// File: rtl/dbg_fn_decode.sv
// Decodes the data function code into a polarity write or a background
// operation. Purely combinational; assumes the caller qualifies nothing else.
module dbg_fn_decode
    import dbg_pkg::*;
(
    input  logic                instr_valid,
    input  logic [FN_W-1:0]     data_fn,
    output logic                pol_we,
    output beat_pol_t           pol_new,
    output bg_op_e              bg_op
);

    // Map the code onto the two datapath controls.
    always_comb begin
        pol_we  = 1'b0;
        pol_new = POL_RESET;
        bg_op   = BG_HOLD;
        if (instr_valid) begin
            case (dbg_fn_e'(data_fn))
                FN_TRUE_TRUE,
                FN_TRUE_INV,
                FN_INV_TRUE,
                FN_INV_INV: begin
                    pol_we           = 1'b1;
                    pol_new.inv_even = data_fn[1];
                    pol_new.inv_odd  = data_fn[0];
                end
                FN_STEP_UP:  bg_op = BG_INC;
                FN_STEP_DN:  bg_op = BG_DEC;
                FN_LOAD_EXT: bg_op = BG_LOAD;
                FN_KEEP:     bg_op = BG_HOLD;
                default:     bg_op = BG_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/dbg_ext_capture.sv
// Holds the tester data word sampled on a strobe that marks a slow-clock
// edge. Assumes the strobe is already synchronous to clk.
module dbg_ext_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] cap_q
);

    // Sample the tester word when strobed, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (capture)
            cap_q <= word_in;
    end

endmodule

// File: rtl/dbg_bg_reg.sv
// Background register with step up/down (modulo 2^DATA_W), load and hold.
// Exposes its next-state value so the output stage can register from it.
module dbg_bg_reg
    import dbg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bg_op_e            op,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] bg_d,
    output logic [DATA_W-1:0] bg_q
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

    // Next background value for the requested operation.
    always_comb begin
        case (op)
            BG_INC:  bg_d = bg_q + STEP;
            BG_DEC:  bg_d = bg_q - STEP;
            BG_LOAD: bg_d = load_val;
            default: bg_d = bg_q;
        endcase
    end

    // Background state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bg_q <= '0;
        else
            bg_q <= bg_d;
    end

endmodule

// File: rtl/dbg_beat_drive.sv
// Holds the beat polarity selection and registers both beat words from the
// next-state background and polarity, so outputs change on the accepting edge.
module dbg_beat_drive
    import dbg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pol_we,
    input  beat_pol_t         pol_new,
    input  logic [DATA_W-1:0] bg_d,
    output logic [DATA_W-1:0] even_q,
    output logic [DATA_W-1:0] odd_q
);

    beat_pol_t         pol_q;
    beat_pol_t         pol_d;
    logic [DATA_W-1:0] even_d;
    logic [DATA_W-1:0] odd_d;

    // Polarity in force after this edge.
    always_comb pol_d = pol_we ? pol_new : pol_q;

    // Per-bit conditional inversion for each beat.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign even_d[b] = bg_d[b] ^ pol_d.inv_even;
        assign odd_d[b]  = bg_d[b] ^ pol_d.inv_odd;
    end

    // Polarity and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= POL_RESET;
            even_q <= '0;
            odd_q  <= '0;
        end else begin
            pol_q  <= pol_d;
            even_q <= even_d;
            odd_q  <= odd_d;
        end
    end

endmodule

// File: rtl/dual_edge_bg_gen.sv
// Top of the dual-edge background generator: decode, tester capture,
// background register and beat drive. Assumes one instruction per clk.
module dual_edge_bg_gen
    import dbg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        data_fn,
    input  logic              ext_capture,
    input  logic [DATA_W-1:0] ext_word,
    output logic [DATA_W-1:0] even_data,
    output logic [DATA_W-1:0] odd_data
);

    logic              pol_we;
    beat_pol_t         pol_new;
    bg_op_e            bg_op;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] bg_d;
    logic [DATA_W-1:0] bg_q;

    dbg_fn_decode u_dec (
        .instr_valid (instr_valid),
        .data_fn     (data_fn),
        .pol_we      (pol_we),
        .pol_new     (pol_new),
        .bg_op       (bg_op)
    );

    dbg_ext_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (ext_capture),
        .word_in (ext_word),
        .cap_q   (cap_q)
    );

    dbg_bg_reg #(.DATA_W(DATA_W)) u_bg (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (bg_op),
        .load_val (cap_q),
        .bg_d     (bg_d),
        .bg_q     (bg_q)
    );

    dbg_beat_drive #(.DATA_W(DATA_W)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .pol_we  (pol_we),
        .pol_new (pol_new),
        .bg_d    (bg_d),
        .even_q  (even_data),
        .odd_q   (odd_data)
    );

endmodule

// File: rtl/dbg_checker.sv
// Temporal checks on the background generator, bound to its top.
module dbg_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [2:0]        data_fn,
    input logic              ext_capture,
    input logic [DATA_W-1:0] ext_word,
    input logic [DATA_W-1:0] even_data,
    input logic [DATA_W-1:0] odd_data,
    input logic [DATA_W-1:0] bg_q,
    input logic [DATA_W-1:0] cap_q
);

    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ONES = '1;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (even_data == '0) && (odd_data == '0));

    // R2
    pol_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !data_fn[2]) |=>
        ((even_data ^ odd_data) == ($past(data_fn[1] ^ data_fn[0]) ? ONES : '0)));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && data_fn == 3'd4) |=> bg_q == $past(bg_q) + ONE);

    // R4
    step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && data_fn == 3'd5) |=> bg_q == $past(bg_q) - ONE);

    // R5
    load_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && data_fn == 3'd6) |=> bg_q == $past(cap_q));

    // R6
    keep_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && data_fn == 3'd7) |=> $stable(even_data) && $stable(odd_data));

    // R7
    pol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && data_fn[2]) |=> $stable(even_data ^ odd_data));

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(even_data) && $stable(odd_data));

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_capture |=> cap_q == $past(ext_word));

endmodule

bind dual_edge_bg_gen dbg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .data_fn     (data_fn),
    .ext_capture (ext_capture),
    .ext_word    (ext_word),
    .even_data   (even_data),
    .odd_data    (odd_data),
    .bg_q        (bg_q),
    .cap_q       (cap_q)
);

// File: tb/dual_edge_bg_gen_tb_top.sv
// Bench: behavioural reference model compared against the ports every cycle.
module dual_edge_bg_gen_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [2:0]    data_fn = 3'd0;
    logic          ext_capture = 1'b0;
    logic [DW-1:0] ext_word = '0;
    logic [DW-1:0] even_data;
    logic [DW-1:0] odd_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference model state
    int unsigned m_bg  = 0;
    int unsigned m_cap = 0;
    bit m_ie = 1'b0;
    bit m_io = 1'b0;
    int unsigned mask = (1 << DW) - 1;

    dual_edge_bg_gen #(.DATA_W(DW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .data_fn     (data_fn),
        .ext_capture (ext_capture),
        .ext_word    (ext_word),
        .even_data   (even_data),
        .odd_data    (odd_data)
    );

    always #10 clk = ~clk;

    task automatic compare(input string req);
        logic [DW-1:0] exp_e;
        logic [DW-1:0] exp_o;
        exp_e = DW'(m_ie ? (~m_bg & mask) : m_bg);
        exp_o = DW'(m_io ? (~m_bg & mask) : m_bg);
        compared++;
        if (even_data !== exp_e || odd_data !== exp_o) begin
            mismatched++;
            $display("FAIL %s: even=%h odd=%h expected even=%h odd=%h",
                     req, even_data, odd_data, exp_e, exp_o);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, check at next negedge.
    task automatic step(input bit v, input int fn, input bit cap,
                        input int unsigned word, input string req);
        int unsigned old_cap;
        instr_valid = v;
        data_fn     = 3'(fn);
        ext_capture = cap;
        ext_word    = DW'(word);
        @(posedge clk);
        old_cap = m_cap;
        if (cap) m_cap = word & mask;
        if (v) begin
            case (fn)
                0, 1, 2, 3: begin m_ie = fn[1]; m_io = fn[0]; end
                4: m_bg = (m_bg + 1) & mask;
                5: m_bg = (m_bg + mask) & mask;
                6: m_bg = old_cap;
                default: ;
            endcase
        end
        @(negedge clk);
        instr_valid = 1'b0;
        ext_capture = 1'b0;
        compare(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        instr_valid = 1'b0;
        ext_capture = 1'b0;
        @(posedge clk);
        m_bg = 0; m_cap = 0; m_ie = 1'b0; m_io = 1'b0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        step(0, 0, 0, 0, "R1");
        // R1: load after reset yields the cleared capture register
        step(1, 6, 0, 0, "R1");

        // R9 / R10: capture alone leaves the outputs unchanged
        step(0, 0, 1, 16'h00F0, "R10");
        step(1, 6, 0, 0, "R5");
        // R2: all four polarity codes
        step(1, 1, 0, 0, "R2");
        step(1, 2, 0, 0, "R2");
        step(1, 3, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        // R3 / R7: step up keeps inverted polarity
        step(1, 3, 0, 0, "R2");
        step(1, 4, 0, 0, "R3");
        step(1, 5, 0, 0, "R4");
        step(1, 7, 0, 0, "R6");
        step(1, 1, 0, 0, "R2");
        step(1, 4, 0, 0, "R7");
        // R4: decrement wraps from zero
        step(0, 0, 1, 16'h0000, "R10");
        step(1, 6, 0, 0, "R5");
        step(1, 5, 0, 0, "R4");
        // R3: increment wraps from all ones
        step(1, 4, 0, 0, "R3");
        // R8: invalid instructions change nothing
        step(0, 4, 0, 0, "R8");
        step(0, 3, 0, 0, "R8");
        step(0, 6, 0, 0, "R8");
        // R9: capture and load at the same edge loads the older word
        step(0, 0, 1, 16'hA5A5, "R9");
        step(1, 6, 1, 16'h1234, "R9");
        step(1, 6, 0, 0, "R9");
        step(1, 2, 0, 0, "R2");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 1)), $urandom, "R7");
        end

        // R1: reset in mid-run
        step(1, 3, 0, 0, "R2");
        do_reset();
        step(1, 4, 0, 0, "R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule